// File: doc/BRIEF.md
# Flash Write-Protection Arbiter

This block sits beside the command decoder of a serial NOR flash and answers one question per request: may this program, erase or status-register write go ahead? It looks at the three block-protect bits, the status-register lock bit, the level of the write-protect pin, and a small configuration register that it holds itself. That register can split the lowest 4 KB sector into four 1 KB sub-sectors, and it gives each of them its own lock bit. A parameter selects a device of 8 Mbit (sixteen 64 KB blocks) or 16 Mbit (thirty-two 64 KB blocks). The count of locked blocks at the top of the array depends on that choice.

The decoder presents the request with an operation code and a 24-bit target address. One clock later the block returns a single grant or refusal. The decoder writes the configuration register through a byte strobe. The block enforces the rules for the split-enable bit: it can be set only while every block-protect bit is 1, and it drops when those bits are all cleared.

Top module: `wp_guard`

## Requirements
- R1: After reset `rsp_valid` and `rsp_allow` are 0 and the configuration register is clear. A request with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle with the decision on `rsp_allow`. Without a request both outputs are 0.
- R2: For an 8 Mbit device the protected blocks are the topmost ones. The block index is address bits 19..16, and the number of locked blocks is 0, 1, 2, 4, 8, 16, 16, 16 for protect codes 0 to 7. A page program (op 0) or sector erase (op 1) aimed at a locked block is refused, and otherwise granted.
- R3: For a 16 Mbit device the block index is address bits 20..16, and the locked-block count is 0, 1, 2, 4, 8, 16, 32, 32 for protect codes 0 to 7. The same grant rule applies.
- R4: Address bits above the device's top bit are ignored: bits 23..20 for 8 Mbit, bits 23..21 for 16 Mbit.
- R5: A chip erase (op 3) is granted only when the protect code is 000.
- R6: A status-register write (op 4) is refused only when the lock bit `srwd` is 1 and `wp_n` is 0.
- R7: The configuration byte holds the split enable in bit 0 and sub-sector locks 0..3 in bits 1..4. Bits 5..7 have no effect, and the register changes only on a write strobe or through R9.
- R8: A write of 1 to the split enable takes effect only if the protect code is 111 in the cycle of the write. Otherwise the bit becomes 0.
- R9: In any cycle where the protect code is 000, the split enable is cleared at the next edge.
- R10: While split is enabled, a page program or sector erase whose address has bits above 11 all zero is judged only by the lock bit selected by address bits 11..10, whatever the protect code. With split disabled the lock bits have no effect.
- R11: A block erase (op 2) is refused if any part of the block is protected. For block 0 with split enabled, that means a locked block or any set sub-sector lock.
- R12: Operation codes 5, 6 and 7 are always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp | input | 3 | Block-protect code from the status register |
| srwd | input | 1 | Status-register lock bit |
| wp_n | input | 1 | Write-protect pin level, low active |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration byte to write |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 page, 1 sector, 2 block, 3 chip, 4 status write |
| req_addr | input | 24 | Target byte address |
| rsp_valid | output | 1 | Decision present |
| rsp_allow | output | 1 | 1 grants the request, 0 refuses it |

## Verification
Page-program requests sweep every protect code against one address inside each of the 32 possible block indices. Both densities are instanced side by side on the same stimulus, so the two range tables and the aliasing of high address bits are told apart in the same cycles. Directed sequences write the configuration byte with the protect code at 111 and at other values, then probe the four sub-sectors, the rest of block 0 and whole-block erases under a later, weaker protect code. This separates protection by sub-sector lock from protection by block, and a set attempt that succeeded from one that was refused. Chip-erase and status-write requests cover every protect code and every lock/pin pair, and the unused operation codes are issued as well.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    OP_PAGE   = 3'd0,
    OP_SECTOR = 3'd1,
    OP_BLOCK  = 3'd2,
    OP_CHIP   = 3'd3,
    OP_STATUS = 3'd4
  } wp_op_e;

  typedef struct packed {
    logic [3:0] sub_lock;
    logic       split_en;
  } wp_cfg_t;

  // Number of 64 KB blocks locked at the top of the array for a protect code.
  function automatic int unsigned bp_top_blocks(input logic [2:0] code,
                                                input int unsigned nblk);
    int unsigned n;
    if (code == 3'd0) return 32'd0;
    n = 32'd1 << (32'(code) - 32'd1);
    return (n > nblk) ? nblk : n;
  endfunction

  // Address width of the byte array for a density given in Mbit.
  function automatic int unsigned array_addr_bits(input int unsigned mbits);
    return $clog2(mbits) + 17;
  endfunction

endpackage

// File: rtl/wp_cfg_reg.sv
module wp_cfg_reg
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bp,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output wp_cfg_t    cfg
);

  logic bp_full;
  logic bp_clear;
  logic split_grant;
  logic unused_rsvd;

  assign bp_full     = &bp;
  assign bp_clear    = (bp == 3'b000);
  assign split_grant = wr_data[0] & bp_full;
  assign unused_rsvd = ^wr_data[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_en) begin
        cfg.sub_lock <= wr_data[4:1];
        cfg.split_en <= split_grant;
      end
      if (bp_clear) begin
        cfg.split_en <= 1'b0;
      end
    end
  end

  AST_SPLIT_NEEDS_FULL_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.split_en ##1 cfg.split_en) |-> ($past(bp) == 3'b111 && $past(wr_en))); // R8

  AST_SPLIT_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 3'b000) |=> !cfg.split_en); // R9

  AST_LOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg.sub_lock)); // R7

endmodule

// File: rtl/wp_region.sv
module wp_region
  import wp_pkg::*;
#(
  parameter int unsigned MBITS = 16
) (
  input  logic [23:0] addr,
  input  logic [2:0]  bp,
  input  wp_cfg_t     cfg,
  output logic        blk_locked,
  output logic        in_split,
  output logic        split_locked,
  output logic        is_block0,
  output logic        any_sub_locked
);

  localparam int unsigned ADDR_W = array_addr_bits(MBITS);
  localparam int unsigned BLK_W  = ADDR_W - 16;
  localparam int unsigned NBLK   = 32'd1 << BLK_W;

  logic [BLK_W-1:0] blk;
  int unsigned      top_n;
  logic             unused_addr_bits;

  assign blk   = addr[ADDR_W-1:16];
  assign top_n = bp_top_blocks(bp, NBLK);

  assign blk_locked     = (top_n != 0) && (32'(blk) >= (NBLK - top_n));
  assign is_block0      = (blk == '0);
  assign in_split       = cfg.split_en && (addr[ADDR_W-1:12] == '0);
  assign split_locked   = cfg.sub_lock[addr[11:10]];
  assign any_sub_locked = cfg.split_en && (|cfg.sub_lock);

  assign unused_addr_bits = ^{addr[23:ADDR_W], addr[9:0]};

endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
(
  input  wp_op_e     op,
  input  logic [2:0] bp,
  input  logic       srwd,
  input  logic       wp_n,
  input  logic       blk_locked,
  input  logic       in_split,
  input  logic       split_locked,
  input  logic       is_block0,
  input  logic       any_sub_locked,
  output logic       allow
);

  logic region_locked;

  assign region_locked = in_split ? split_locked : blk_locked;

  always_comb begin
    unique case (op)
      OP_PAGE,
      OP_SECTOR: allow = !region_locked;
      OP_BLOCK:  allow = !(blk_locked || (is_block0 && any_sub_locked));
      OP_CHIP:   allow = (bp == 3'b000);
      OP_STATUS: allow = !(srwd && !wp_n);
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int unsigned MBITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bp,
  input  logic        srwd,
  input  logic        wp_n,
  input  logic        cfg_wr_en,
  input  logic [7:0]  cfg_wr_data,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_allow
);

  wp_cfg_t cfg;
  logic    blk_locked;
  logic    in_split;
  logic    split_locked;
  logic    is_block0;
  logic    any_sub_locked;
  logic    allow_now;

  wp_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .bp      (bp),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg)
  );

  wp_region #(.MBITS(MBITS)) u_region (
    .addr           (req_addr),
    .bp             (bp),
    .cfg            (cfg),
    .blk_locked     (blk_locked),
    .in_split       (in_split),
    .split_locked   (split_locked),
    .is_block0      (is_block0),
    .any_sub_locked (any_sub_locked)
  );

  wp_decide u_decide (
    .op             (wp_op_e'(req_op)),
    .bp             (bp),
    .srwd           (srwd),
    .wp_n           (wp_n),
    .blk_locked     (blk_locked),
    .in_split       (in_split),
    .split_locked   (split_locked),
    .is_block0      (is_block0),
    .any_sub_locked (any_sub_locked),
    .allow          (allow_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && allow_now;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1

  AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow)); // R1

  AST_CHIP_NEEDS_NO_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && bp != 3'b000) |=> !rsp_allow); // R5

  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4 && srwd && !wp_n) |=> !rsp_allow); // R6

  AST_UNKNOWN_OP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > 3'd4) |=> !rsp_allow); // R12

endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bp = 3'b000;
  logic        srwd = 1'b0;
  logic        wp_n = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_data = 8'h00;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [23:0] req_addr = 24'h0;
  logic        rsp_valid, rsp_allow;
  logic        rsp_valid_b, rsp_allow_b;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // model state
  bit    m_split;
  bit [3:0] m_lock;
  bit    e_valid;
  bit    e_allow16, e_allow8;
  string e_tag;

  always #4 clk = ~clk;

  wp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bp(bp), .srwd(srwd), .wp_n(wp_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
  );

  wp_guard #(.MBITS(8)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bp(bp), .srwd(srwd), .wp_n(wp_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid_b), .rsp_allow(rsp_allow_b)
  );

  function automatic int locked_count(int mbits, int code);
    if (mbits == 8) begin
      case (code)
        0: return 0;  1: return 1;  2: return 2;  3: return 4;
        4: return 8;  default: return 16;
      endcase
    end
    case (code)
      0: return 0;  1: return 1;  2: return 2;  3: return 4;
      4: return 8;  5: return 16; default: return 32;
    endcase
  endfunction

  function automatic bit ref_allow(int mbits, int op, int addr, int code,
                                   bit lockbit, bit pin_n, bit split, bit [3:0] locks);
    int size, a, nblk, blk, top;
    bit blocked, sub;
    size = mbits * 131072;
    a    = addr % size;
    nblk = mbits * 2;
    blk  = a / 65536;
    top  = locked_count(mbits, code);
    blocked = (blk >= nblk - top);
    sub  = split && (a < 4096);
    case (op)
      0, 1: return sub ? !locks[a / 1024] : !blocked;
      2:    return !(blocked || (blk == 0 && split && locks != 4'b0));
      3:    return code == 0;
      4:    return !(lockbit && !pin_n);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_split = 1'b0; m_lock = 4'b0; e_valid = 1'b0;
      e_allow16 = 1'b0; e_allow8 = 1'b0; e_tag = "R1";
    end else begin
      e_valid   = req_valid;
      e_allow16 = req_valid && ref_allow(16, int'(req_op), int'(req_addr), int'(bp),
                                         srwd, wp_n, m_split, m_lock);
      e_allow8  = req_valid && ref_allow(8, int'(req_op), int'(req_addr), int'(bp),
                                         srwd, wp_n, m_split, m_lock);
      e_tag = tag;
      if (cfg_wr_en) begin
        m_lock  = cfg_wr_data[4:1];
        m_split = cfg_wr_data[0] && (bp == 3'b111);
      end
      if (bp == 3'b000) m_split = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (rsp_valid !== e_valid || rsp_allow !== e_allow16) begin
        errors++;
        $display("FAIL %s 16Mbit: valid=%0d allow=%0d expected valid=%0d allow=%0d",
                 e_tag, rsp_valid, rsp_allow, e_valid, e_allow16);
      end
      if (rsp_valid_b !== e_valid || rsp_allow_b !== e_allow8) begin
        errors++;
        $display("FAIL %s 8Mbit: valid=%0d allow=%0d expected valid=%0d allow=%0d",
                 e_tag, rsp_valid_b, rsp_allow_b, e_valid, e_allow8);
      end
    end
  end

  task automatic req(input int op, input int addr);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    req_valid = 1'b1;
    req_op    = op[2:0];
    req_addr  = addr[23:0];
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_wr_en = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic cfgw(input logic [7:0] d);
    @(negedge clk);
    req_valid   = 1'b0;
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
  endtask

  task automatic probe_split();
    req(1, 24'h000000); req(1, 24'h000400); req(1, 24'h000800);
    req(0, 24'h000C10); req(1, 24'h001000); req(2, 24'h000000);
    req(2, 24'h010000);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks += 4;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_valid_b !== 1'b0 || rsp_allow_b !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0d allow=%0d expected valid=0 allow=0", rsp_valid, rsp_allow);
    end
    rst_n = 1'b1;
    idle();

    // R2 R3: block ranges for both densities
    tag = "R2 R3";
    for (int c = 0; c < 8; c++) begin
      bp = c[2:0];
      for (int b = 0; b < 32; b++) req(0, b * 65536 + 16'h0123);
      req(1, 24'h1FF000);
      req(2, 24'h0F0000);
    end

    // R4: upper address bits ignored
    tag = "R4";
    for (int c = 1; c < 8; c++) begin
      bp = c[2:0];
      req(0, 24'hE00000 | 24'h0F8000);
      req(1, 24'hC00000 | 24'h1F0000);
      req(0, 24'hF00000 | 24'h0E1234);
    end

    // R5: chip erase vs every protect code
    tag = "R5";
    for (int c = 0; c < 8; c++) begin bp = c[2:0]; req(3, 24'h000000); end

    // R6: status write vs lock bit and pin
    tag = "R6";
    bp = 3'b011;
    for (int s = 0; s < 4; s++) begin
      srwd = s[0]; wp_n = s[1];
      req(4, 24'h0);
    end
    srwd = 1'b0; wp_n = 1'b1;

    // R12: unused opcodes
    tag = "R12";
    bp = 3'b000;
    for (int o = 5; o < 8; o++) req(o, 24'h012345);

    // R8: set attempt refused while code is not all ones
    tag = "R8";
    bp = 3'b001;
    cfgw(8'h1F);
    probe_split();

    // R8 R10: set while code is 111; reserved bits set too (R7)
    tag = "R10";
    bp = 3'b111;
    cfgw(8'hE3);
    probe_split();

    // R10 R11: weaker code keeps split; block 0 judged on sub-sector locks
    tag = "R11";
    bp = 3'b001;
    probe_split();
    cfgw(8'h11);
    probe_split();

    // R7: clearing the byte drops split and locks
    tag = "R7";
    cfgw(8'h00);
    probe_split();

    // R9: code 000 clears split
    tag = "R9";
    bp = 3'b111;
    cfgw(8'h1F);
    probe_split();
    bp = 3'b000;
    idle();
    bp = 3'b001;
    probe_split();

    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule